// File: doc/BRIEF.md
# UART Receive Character Queue

This block holds characters that a UART receiver has already assembled, waiting for software to take them. Each stored word is twelve bits wide: an 8-bit character in bits 7:0 and a 4-bit error nibble in bits 11:8. When the nibble is read out, bit 8 is the framing error, bit 9 is the parity error, bit 10 is the break and bit 11 is the overrun. A mode input picks how deep the queue is. When the mode input is high, the queue is a 16-entry first-in first-out buffer. When it is low, the queue is a single holding register. Changing the mode input in either direction throws away the queue contents.

The block drives empty and full flags and a can-accept output that the receiver uses as backpressure. It also raises a receive interrupt level once the fill level reaches a trigger count. That count is a parameter, and its default is 1. Every data-register read pops one entry. The pop copies the entry's error nibble into a receive-status register, which stays readable until software clears it with a write. A line-break event that arrives while the queue is in single-register mode stores a break word and flags the break in the status register.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the outputs are: empty=1, full=0, can_accept=1, rx_irq=0 and rx_status=0.
- R2: With fifo_en=1, the queue holds 16 words and returns them in arrival order. The head word appears on rd_word. full=1 and can_accept=0 exactly when 16 words are held, and empty=1 exactly when none are held.
- R3: A push offered while the queue already holds its effective depth, with no pop in the same cycle, is dropped. The contents and the count do not change.
- R4: With fifo_en=0, the effective depth is 1. One push sets full=1, and a second push is dropped.
- R5: A change of fifo_en in either direction empties the queue in that cycle and sets empty=1 and full=0. Any push or pop offered in that cycle is ignored, and rx_irq keeps its value.
- R6: A pop strobe on an empty queue leaves the queue empty.
- R7: rx_irq rises when a push brings the count up to the trigger level (default 1). It falls when a pop brings the count down to one below that level, and it is otherwise held.
- R8: A pop loads the popped word's bits 11:8 into rx_status. A status_clr strobe clears rx_status and wins over a pop load in the same cycle.
- R9: A break_evt in single-register mode pushes the word 0x400 (bit 10 set) and sets rx_status bit 2. A break_evt in FIFO mode has no effect on the queue.
- R10: The read and write positions wrap modulo 16, so order is kept across any number of passes through the storage.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-entry FIFO, 0 = single holding register |
| push_valid | input | 1 | Receiver offers a character this cycle |
| push_data | input | 8 | Received character |
| push_err | input | 4 | Error nibble of the character (framing, parity, break, overrun) |
| pop | input | 1 | Data-register read strobe |
| break_evt | input | 1 | Line-break event |
| status_clr | input | 1 | Write strobe to the receive-status register |
| rd_word | output | 12 | Head word {error, data} |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds its effective depth |
| can_accept | output | 1 | Count is below the effective depth |
| rx_irq | output | 1 | Receive interrupt level |
| rx_status | output | 4 | Receive-status error nibble |

## Verification
Flags, count, interrupt level and status are all registered, so the effect of a stimulus applied before a rising edge is due immediately after that edge. rd_word is a combinational view of the head, so it shows a new head in that same post-edge interval. The bench drives inputs after a falling edge and samples every output at the next falling edge, so each check sees exactly one edge of effect. A mode change is given its own cycle, with no push or pop alongside it.

// File: rtl/uart_rxq_pkg.sv
// Package: shared widths and word layout for the receive queue.
// Assumes the error nibble order framing, parity, break, overrun (bits 0..3).
package uart_rxq_pkg;
    localparam int DATA_W  = 8;
    localparam int ERR_W   = 4;
    localparam int WORD_W  = DATA_W + ERR_W;
    localparam int BRK_BIT = 2;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rxq_word_t;

    // Word stored when a line break is seen: zero data, break error flagged.
    function automatic rxq_word_t break_word();
        rxq_word_t w;
        w.data = '0;
        w.err  = '0;
        w.err[BRK_BIT] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/uart_rxq_store.sv
// Module: entry storage. One register per entry, one write port and a
// combinational head read. Assumes the controller never writes and
// reads the same slot with conflicting intent; contents are not reset.
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_slot,
    input  rxq_word_t        wr_word,
    input  logic [PTR_W-1:0] rd_slot,
    output rxq_word_t        head
);
    rxq_word_t entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Capture the incoming word when this slot is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == PTR_W'(g)) begin
                entry[g] <= wr_word;
            end
        end
    end

    // Present the word at the read position.
    assign head = entry[rd_slot];
endmodule

// File: rtl/uart_rxq_ctrl.sv
// Module: occupancy control. Tracks read position and count, applies the
// run-time depth (DEPTH or 1), flushes on a mode change, and keeps the
// empty/full flags and the trigger-level interrupt. Assumes TRIG in 1..DEPTH.
module uart_rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             mode_q,
    output logic             empty,
    output logic             full,
    output logic             can_accept,
    output logic             irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(TRIG);
    localparam logic [CNT_W-1:0] TRIG_LO  = CNT_W'(TRIG - 1);

    logic [CNT_W-1:0] count, count_n, depth_eff;
    logic [PTR_W-1:0] mask;
    logic             toggle, push_ok, pop_ok;

    // Decode the mode in force and the admissibility of this cycle's requests.
    always_comb begin
        toggle    = fifo_en ^ mode_q;
        depth_eff = mode_q ? FULL_CNT : CNT_W'(1);
        mask      = mode_q ? PTR_W'(DEPTH - 1) : '0;
        push_ok   = wr_req && !toggle && (count < depth_eff);
        pop_ok    = rd_req && !toggle && (count != '0);
        count_n   = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        wr_slot   = (rd_ptr + count[PTR_W-1:0]) & mask;
        wr_en     = push_ok;
    end

    assign can_accept = (count < depth_eff);

    // Advance count and read position, or flush on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            rd_ptr <= '0;
            mode_q <= fifo_en;
        end else if (toggle) begin
            count  <= '0;
            rd_ptr <= '0;
            mode_q <= fifo_en;
        end else begin
            count <= count_n;
            if (pop_ok) rd_ptr <= (rd_ptr + PTR_W'(1)) & mask;
        end
    end

    // Keep the empty/full flags in step with the next count.
    always_ff @(posedge clk) begin
        if (!rst_n || toggle) begin
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            empty <= (count_n == '0);
            full  <= (count_n == depth_eff);
        end
    end

    // Raise on reaching the trigger by a push, drop on falling below it by a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (push_ok && count_n == TRIG_CNT) begin
            irq <= 1'b1;
        end else if (pop_ok && count_n == TRIG_LO) begin
            irq <= 1'b0;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= depth_eff) else $error("count above depth"); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req && !toggle && count == depth_eff) |=> $stable(count)) else $error("push accepted when full"); // R3
    AST_SINGLE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !toggle) |-> count <= CNT_W'(1)) else $error("single mode overfilled"); // R4
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (empty && !full && count == '0 && rd_ptr == '0)) else $error("flush incomplete"); // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_req && !wr_req && !toggle) |=> empty) else $error("pop on empty changed state"); // R6
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_req)) else $error("irq rose without push"); // R7
endmodule

// File: rtl/uart_rxq_status.sv
// Module: receive-status error nibble. Loads the error bits of each popped
// word, ORs in the break flag, and clears on a status write.
module uart_rxq_status
    import uart_rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ERR_W-1:0] head_err,
    input  logic             clr,
    input  logic             brk_set,
    output logic [ERR_W-1:0] stat
);
    logic [ERR_W-1:0] stat_n;

    // Pick clear, load or hold, then flag a break on top.
    always_comb begin
        if (clr)       stat_n = '0;
        else if (load) stat_n = head_err;
        else           stat_n = stat;
        if (brk_set) stat_n[BRK_BIT] = 1'b1;
    end

    // Register the status nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_n;
    end

    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !brk_set) |=> stat == '0) else $error("status not cleared"); // R8
    AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr && !brk_set) |=> stat == $past(head_err)) else $error("status not loaded"); // R8
    AST_BRK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_set |=> stat[BRK_BIT]) else $error("break not flagged"); // R9
endmodule

// File: rtl/uart_rx_queue.sv
// Module: top of the UART receive queue. Merges break events into the push
// path, wires storage, occupancy control and the status nibble.
// Assumes push and pop requests are single-cycle strobes.
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ERR_W-1:0]  push_err,
    input  logic              pop,
    input  logic              break_evt,
    input  logic              status_clr,
    output logic [WORD_W-1:0] rd_word,
    output logic              empty,
    output logic              full,
    output logic              can_accept,
    output logic              rx_irq,
    output logic [ERR_W-1:0]  rx_status
);
    logic             mode_q, brk_push, wr_en;
    logic [PTR_W-1:0] wr_slot, rd_ptr;
    rxq_word_t        in_word, head;

    // A break only enters the queue in single-register mode.
    always_comb begin
        brk_push = break_evt && !mode_q && !fifo_en;
        if (brk_push) begin
            in_word = break_word();
        end else begin
            in_word.data = push_data;
            in_word.err  = push_err;
        end
    end

    uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .wr_req     (push_valid || brk_push),
        .rd_req     (pop),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .rd_ptr     (rd_ptr),
        .mode_q     (mode_q),
        .empty      (empty),
        .full       (full),
        .can_accept (can_accept),
        .irq        (rx_irq)
    );

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_word (in_word),
        .rd_slot (rd_ptr),
        .head    (head)
    );

    uart_rxq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pop),
        .head_err (head.err),
        .clr      (status_clr),
        .brk_set  (brk_push),
        .stat     (rx_status)
    );

    assign rd_word = head;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)) else $error("empty and full together"); // R2
    AST_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && fifo_en == mode_q) |-> !can_accept) else $error("accepting while full"); // R2
endmodule

// File: tb/uart_rx_queue_bench.sv
`timescale 1ns/1ps
module uart_rx_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic [3:0]  push_err = '0;
    logic        pop = 1'b0;
    logic        break_evt = 1'b0;
    logic        status_clr = 1'b0;
    logic [11:0] rd_word;
    logic        empty, full, can_accept, rx_irq;
    logic [3:0]  rx_status;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Bench model state.
    logic [11:0] q[$];
    bit          m_mode = 1;
    bit          m_irq  = 0;
    logic [3:0]  m_stat = '0;
    bit          stat_known = 1;

    always #2 clk = ~clk;

    uart_rx_queue u_uart_rx_queue (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
        .push_data(push_data), .push_err(push_err), .pop(pop),
        .break_evt(break_evt), .status_clr(status_clr), .rd_word(rd_word),
        .empty(empty), .full(full), .can_accept(can_accept),
        .rx_irq(rx_irq), .rx_status(rx_status)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic check_all(input string tag);
        int depth = m_mode ? 16 : 1;
        chk(tag, "empty", empty, q.size() == 0);
        chk(tag, "full", full, q.size() == depth);
        chk(tag, "can_accept", can_accept, q.size() < depth);
        chk(tag, "rx_irq", rx_irq, m_irq);
        if (q.size() > 0) chk(tag, "rd_word", rd_word, q[0]);
        if (stat_known) chk(tag, "rx_status", rx_status, m_stat);
    endtask

    // One cycle of stimulus; the model is advanced and outputs checked after the edge.
    task automatic cyc(input string tag, input bit pv, input logic [7:0] pd,
                       input logic [3:0] pe, input bit pp, input bit brk, input bit clr);
        int depth = m_mode ? 16 : 1;
        bit brkp = brk && !m_mode;
        bit push_ok = (pv || brkp) && q.size() < depth;
        bit pop_ok = pp && q.size() > 0;
        logic [11:0] w = brkp ? 12'h400 : {pe, pd};
        if (clr) begin m_stat = '0; stat_known = 1; end
        else if (pp) begin
            if (q.size() > 0) begin m_stat = q[0][11:8]; stat_known = 1; end
            else stat_known = 0;
        end
        if (brkp) m_stat[2] = 1'b1;
        if (pop_ok) void'(q.pop_front());
        if (push_ok) q.push_back(w);
        if (push_ok && q.size() == 1) m_irq = 1;
        else if (pop_ok && q.size() == 0) m_irq = 0;
        push_valid = pv; push_data = pd; push_err = pe; pop = pp;
        break_evt = brk; status_clr = clr;
        @(negedge clk);
        push_valid = 0; pop = 0; break_evt = 0; status_clr = 0;
        check_all(tag);
    endtask

    // Mode change on its own cycle: flush, irq held.
    task automatic set_mode(input string tag, input bit m);
        fifo_en = m;
        m_mode = m;
        q.delete();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: fill 16 entries in FIFO mode, every count level checked.
        for (int i = 0; i < 16; i++) cyc("R2", 1, 8'(i * 37 + 5), 4'(i), 0, 0, 0);
        // R3: push into a full queue is dropped.
        cyc("R3", 1, 8'hEE, 4'hF, 0, 0, 0);
        chk("R3", "count", q.size(), 16);
        // R2/R8: drain in order, status takes each popped nibble.
        for (int i = 0; i < 16; i++) cyc("R8", 0, 0, 0, 1, 0, 0);
        // R6: pop on empty.
        cyc("R6", 0, 0, 0, 1, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0);

        // R8: load, then clear, then clear beating a load.
        cyc("R8", 1, 8'h41, 4'hA, 0, 0, 0);
        cyc("R8", 0, 0, 0, 1, 0, 0);
        chk("R8", "rx_status", rx_status, 4'hA);
        cyc("R8", 0, 0, 0, 0, 0, 1);
        cyc("R8", 1, 8'h42, 4'h5, 0, 0, 0);
        cyc("R8", 0, 0, 0, 1, 0, 1);
        chk("R8", "rx_status", rx_status, 0);

        // R10/R11: keep three in flight across many wraps.
        for (int i = 0; i < 3; i++) cyc("R10", 1, 8'(100 + i), 4'(i), 0, 0, 0);
        for (int i = 0; i < 45; i++) cyc("R11", 1, 8'(i * 11), 4'(i * 3), 1, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R10", 0, 0, 0, 1, 0, 0);
        // Sweep every fill level then drain across the wrap point.
        for (int n = 1; n <= 16; n++) begin
            for (int i = 0; i < n; i++) cyc("R10", 1, 8'(n * 16 + i), 4'(n), 0, 0, 0);
            for (int i = 0; i < n; i++) cyc("R10", 0, 0, 0, 1, 0, 0);
        end

        // R9: break in FIFO mode is ignored.
        cyc("R9", 0, 0, 0, 0, 1, 0);
        chk("R9", "empty", empty, 1);

        // R5/R7: flush keeps irq set.
        cyc("R7", 1, 8'h10, 4'h0, 0, 0, 0);
        cyc("R7", 1, 8'h11, 4'h0, 0, 0, 0);
        set_mode("R5", 0);
        chk("R5", "rx_irq", rx_irq, 1);

        // R4: single-register mode.
        cyc("R4", 1, 8'h77, 4'h1, 0, 0, 0);
        cyc("R4", 1, 8'h78, 4'h2, 0, 0, 0);
        chk("R4", "rd_word", rd_word, 12'h177);
        cyc("R4", 0, 0, 0, 1, 0, 0);
        chk("R7", "rx_irq", rx_irq, 0);

        // R9: break in single mode.
        cyc("R9", 0, 0, 0, 0, 0, 1);
        cyc("R9", 0, 0, 0, 0, 1, 0);
        chk("R9", "rd_word", rd_word, 12'h400);
        chk("R9", "rx_status", rx_status, 4'h4);
        cyc("R9", 0, 0, 0, 1, 0, 0);

        // R5: flush toward FIFO mode discards a held word.
        cyc("R5", 1, 8'h5A, 4'h0, 0, 0, 0);
        set_mode("R5", 1);
        cyc("R5", 1, 8'h5B, 4'h3, 0, 0, 0);
        chk("R5", "rd_word", rd_word, 12'h35B);
        cyc("R5", 0, 0, 0, 1, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule